// File: doc/BRIEF.md
# Dual-Modulus Shared-Prefix Subtractor

This combinational unit takes two N-bit residues and delivers their difference, minuend minus subtrahend, under two moduli at once: modulo 2^N and modulo 2^N−1. The subtraction is carried out as the minuend plus the one's complement of the subtrahend. A single parallel-prefix carry network computes the group generate and propagate signals for that sum.

Two carry-incorporation tracks read the same prefix output side by side. The first track injects a constant carry-in of one, which completes the two's-complement difference. The second track feeds the network's own carry-out back in as an end-around carry, which gives the one's-complement difference. A borrow flag reports when the minuend is smaller than the subtrahend.

A typical use is the pair of channels of a residue scaler where a 2^N and a 2^N−1 difference of the same operands are needed in the same cycle.

Top module: `dms_dual_sub`

## Requirements
- R1: `diff_pow2` equals (minuend − subtrahend) mod 2^N for every pair of N-bit operands.
- R2: `diff_mers` equals (minuend − subtrahend) mod (2^N−1), given as the least non-negative value in 0..2^N−2. It is never all ones.
- R3: `borrow` is 1 exactly when minuend < subtrahend as unsigned integers. When `borrow` is 1, `diff_mers` is one less than `diff_pow2`.
- R4: Equal operands give `diff_pow2` = 0, `diff_mers` = 0 and `borrow` = 0.
- R5: An operand of all ones counts as zero in the 2^N−1 result. For example, minuend all ones and subtrahend 0 give `diff_mers` = 0 and `diff_pow2` all ones. Minuend 0 and subtrahend all ones give `diff_mers` = 0 with `borrow` = 1.
- R6: R1–R3 hold for any width N ≥ 2, including N = 2 and N = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| minuend | input | N | Operand the other is taken from |
| subtrahend | input | N | Operand being subtracted |
| diff_pow2 | output | N | Difference modulo 2^N |
| diff_mers | output | N | Difference modulo 2^N−1, canonical form |
| borrow | output | 1 | Minuend smaller than subtrahend |

## Verification
The bench targets equal operands and all-ones operands in the 2^N−1 channel. An end-around track that skipped the all-ones fold would output 2^N−1 instead of zero there. It also targets the boundary between borrow and no borrow (0 − max and max − 0). A swapped or missing carry-in would shift one result by one or invert the borrow flag at exactly these points. Exhaustive sweeps at N = 2 and N = 8, plus random pairs at N = 16, catch a prefix network that drops a span at some level. Such a fault would give wrong carries only for particular long propagate runs.

// File: rtl/dms_pkg.sv
package dms_pkg;
  // number of prefix levels for an n-bit carry tree
  function automatic int prefix_levels(input int n);
    int l;
    l = 0;
    while ((1 << l) < n) l++;
    return (l < 1) ? 1 : l;
  endfunction
endpackage

// File: rtl/dms_bitgen.sv
module dms_bitgen #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] gen,
  output logic [N-1:0] prop
);
  logic [N-1:0] b_inv;
  assign b_inv = ~b;
  assign gen   = a & b_inv;
  assign prop  = a ^ b_inv;
endmodule

// File: rtl/dms_prefix_tree.sv
module dms_prefix_tree #(
  parameter int N = 8
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:0] p_in,
  output logic [N-1:0] g_grp,
  output logic [N-1:0] p_grp
);
  localparam int LVL = dms_pkg::prefix_levels(N);

  logic [N-1:0] gs [0:LVL];
  logic [N-1:0] ps [0:LVL];

  assign gs[0] = g_in;
  assign ps[0] = p_in;

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= D) begin : g_op
        assign gs[l+1][i] = gs[l][i] | (ps[l][i] & gs[l][i-D]);
        assign ps[l+1][i] = ps[l][i] & ps[l][i-D];
      end else begin : g_pass
        assign gs[l+1][i] = gs[l][i];
        assign ps[l+1][i] = ps[l][i];
      end
    end
  end

  assign g_grp = gs[LVL];
  assign p_grp = ps[LVL];
endmodule

// File: rtl/dms_carry_track.sv
module dms_carry_track #(
  parameter int N = 8
) (
  input  logic [N-1:0] prop,
  input  logic [N-2:0] g_lo,
  input  logic [N-2:0] p_lo,
  input  logic         cin,
  output logic [N-1:0] sum
);
  logic [N-1:0] carry;

  assign carry[0] = cin;
  for (genvar i = 1; i < N; i++) begin : g_c
    assign carry[i] = g_lo[i-1] | (p_lo[i-1] & cin);
  end

  assign sum = prop ^ carry;
endmodule

// File: rtl/dms_dual_sub.sv
module dms_dual_sub #(
  parameter int N = 8
) (
  input  logic [N-1:0] minuend,
  input  logic [N-1:0] subtrahend,
  output logic [N-1:0] diff_pow2,
  output logic [N-1:0] diff_mers,
  output logic         borrow
);
  logic [N-1:0] gen_b, prop_b;
  logic [N-1:0] g_grp, p_grp;
  logic [N-1:0] sum_one, sum_end;
  logic         net_cout;

  dms_bitgen #(.N(N)) u_gen (
    .a(minuend), .b(subtrahend), .gen(gen_b), .prop(prop_b)
  );

  dms_prefix_tree #(.N(N)) u_tree (
    .g_in(gen_b), .p_in(prop_b), .g_grp(g_grp), .p_grp(p_grp)
  );

  assign net_cout = g_grp[N-1];

  dms_carry_track #(.N(N)) u_trk_one (
    .prop(prop_b), .g_lo(g_grp[N-2:0]), .p_lo(p_grp[N-2:0]),
    .cin(1'b1), .sum(sum_one)
  );

  dms_carry_track #(.N(N)) u_trk_end (
    .prop(prop_b), .g_lo(g_grp[N-2:0]), .p_lo(p_grp[N-2:0]),
    .cin(net_cout), .sum(sum_end)
  );

  assign diff_pow2 = sum_one;
  assign diff_mers = (&sum_end) ? '0 : sum_end;
  assign borrow    = ~(g_grp[N-1] | p_grp[N-1]);
endmodule

// File: rtl/dms_dual_sub_chk.sv
module dms_dual_sub_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] minuend,
  input logic [N-1:0] subtrahend,
  input logic [N-1:0] diff_pow2,
  input logic [N-1:0] diff_mers,
  input logic         borrow
);
  logic [N-1:0] pow2_dec;
  logic [N-1:0] pow2_fold;
  assign pow2_dec  = diff_pow2 - {{(N-1){1'b0}}, 1'b1};
  assign pow2_fold = (&diff_pow2) ? '0 : diff_pow2;

  always_comb begin
    AST_MERS_CANON: assert (!(&diff_mers)) else $error("mers all ones");  // R2
    AST_NOBORROW_MATCH: assert (borrow || diff_mers == pow2_fold) else $error("no-borrow mismatch");  // R1
    AST_BORROW_OFFSET: assert (!borrow || diff_mers == pow2_dec) else $error("borrow offset");  // R3
    AST_BORROW_NONZERO: assert (!borrow || diff_pow2 != '0) else $error("borrow with zero diff");  // R3
    AST_EQUAL_ZERO: assert (minuend != subtrahend || (diff_pow2 == '0 && diff_mers == '0 && !borrow)) else $error("equal operands");  // R4
  end
endmodule

bind dms_dual_sub dms_dual_sub_chk #(.N(N)) u_chk (
  .minuend(minuend), .subtrahend(subtrahend),
  .diff_pow2(diff_pow2), .diff_mers(diff_mers), .borrow(borrow)
);

// File: tb/tb_dms_dual_sub.sv
module tb_dms_dual_sub;
  logic clk;
  logic rst_n;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  a8, b8, p8, m8;
  logic        br8;
  logic [15:0] a16, b16, p16, m16;
  logic        br16;
  logic [1:0]  a2, b2, p2, m2;
  logic        br2;

  dms_dual_sub #(.N(8)) dut (
    .minuend(a8), .subtrahend(b8), .diff_pow2(p8), .diff_mers(m8), .borrow(br8)
  );
  dms_dual_sub #(.N(16)) dut16 (
    .minuend(a16), .subtrahend(b16), .diff_pow2(p16), .diff_mers(m16), .borrow(br16)
  );
  dms_dual_sub #(.N(2)) dut2 (
    .minuend(a2), .subtrahend(b2), .diff_pow2(p2), .diff_mers(m2), .borrow(br2)
  );

  function automatic longint ref_p2(longint a, longint b, int n);
    return (a - b) & ((longint'(1) << n) - 1);
  endfunction

  function automatic longint ref_m1(longint a, longint b, int n);
    longint md, r;
    md = (longint'(1) << n) - 1;
    r  = (a - b) % md;
    if (r < 0) r += md;
    return r;
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic apply8(logic [7:0] a, logic [7:0] b);
    @(posedge clk);
    a8 = a; b8 = b;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R4 reset diff_pow2", p8, 0);
    chk("R4 reset diff_mers", m8, 0);
    chk("R4 reset borrow", br8, 0);
  endtask

  task automatic t_equal_ops();
    foreach (b8[k]) begin
      logic [7:0] v;
      v = 8'(1 << k) | 8'(k);
      apply8(v, v);
      chk("R4 equal diff_pow2", p8, 0);
      chk("R4 equal diff_mers", m8, 0);
      chk("R4 equal borrow", br8, 0);
    end
  endtask

  task automatic t_all_ones();
    apply8(8'hFF, 8'h00);
    chk("R5 max-0 diff_mers", m8, 0);
    chk("R5 max-0 diff_pow2", p8, 255);
    chk("R5 max-0 borrow", br8, 0);
    apply8(8'h00, 8'hFF);
    chk("R5 0-max diff_mers", m8, 0);
    chk("R5 0-max diff_pow2", p8, 1);
    chk("R3 0-max borrow", br8, 1);
    apply8(8'hFF, 8'h05);
    chk("R5 max-5 diff_mers", m8, 250);
    apply8(8'h05, 8'hFF);
    chk("R5 5-max diff_mers", m8, 5);
  endtask

  task automatic t_exhaustive8();
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply8(8'(a), 8'(b));
        chk("R1 n8 diff_pow2", p8, ref_p2(a, b, 8));
        chk("R2 n8 diff_mers", m8, ref_m1(a, b, 8));
        chk("R3 n8 borrow", br8, (a < b) ? 1 : 0);
      end
    end
  endtask

  task automatic t_exhaustive2();
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        @(posedge clk);
        a2 = 2'(a); b2 = 2'(b);
        @(negedge clk);
        chk("R6 n2 diff_pow2", p2, ref_p2(a, b, 2));
        chk("R6 n2 diff_mers", m2, ref_m1(a, b, 2));
        chk("R6 n2 borrow", br2, (a < b) ? 1 : 0);
      end
    end
  endtask

  task automatic t_random16();
    for (int k = 0; k < 3000; k++) begin
      longint a, b;
      a = longint'($urandom & 32'hFFFF);
      b = longint'($urandom & 32'hFFFF);
      if (k == 0) begin a = 65535; b = 0; end
      if (k == 1) begin a = 0; b = 65535; end
      if (k == 2) begin a = 32768; b = 32767; end
      @(posedge clk);
      a16 = 16'(a); b16 = 16'(b);
      @(negedge clk);
      chk("R6 n16 diff_pow2", p16, ref_p2(a, b, 16));
      chk("R6 n16 diff_mers", m16, ref_m1(a, b, 16));
      chk("R6 n16 borrow", br16, (a < b) ? 1 : 0);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    a8 = '0; b8 = '0; a16 = '0; b16 = '0; a2 = '0; b2 = '0;
    repeat (3) @(posedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_equal_ops();
    t_all_ones();
    t_exhaustive2();
    t_random16();
    t_exhaustive8();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule